// File: doc/BRIEF.md
# DMA Channel Request and Transfer Sequencer

This block holds the control state of a single DMA channel and decides when the channel asks for the bus. Software writes a control word and a transfer count. The control word selects the request source, the request sensing, the bus mode, the unit size and the interrupt enable. The request source can be an external active-low pin, an on-chip peripheral line, or auto-request. The channel then raises a bus request. It runs transfer cycles of the chosen size through a request/grant/done handshake and counts completed units down to zero. When the count reaches zero it sets an end flag, and it can raise an interrupt.

Address generation, the data path and arbitration between channels belong to other blocks. A parameter gives the channel index. Only the lowest-numbered channels (parameter `NUM_EDGE_CHANS`) can select edge sensing for the external pin.

Control word layout: bit 0 enable, bit 1 end flag, bit 2 interrupt enable, bits 4:3 size, bit 5 burst, bit 6 edge select, bits 8:7 source.

Top module: `dma_chan_ctl`

## Requirements
- R1: After reset, the control readback is 0, the count readback is 0, and `bus_req` and `irq` are low.
- R2: With source code 1x (auto), the enable bit set, the end flag clear and a nonzero count, the channel requests the bus with no pin activity. With a count of 0 it never requests.
- R3: Size field 00, 01 and 10 gives `cyc_size` equal to the field: byte, word and longword. Size 11 gives four cycles per unit, each with `cyc_size` 10.
- R4: The count drops by one for each completed unit. When it reaches zero the end flag (bit 1) is set and the bus request is removed.
- R5: With bit 5 at 0 (cycle-steal), `bus_req` goes low for at least one cycle after every unit.
- R6: With bit 5 at 1 (burst), `bus_req` stays high from the first unit until the count is exhausted. The pin is not re-checked between units.
- R7: While the end flag is set, no request is made. A control write with bit 1 = 0 clears the flag. A write with bit 1 = 1 leaves it unchanged.
- R8: `irq` is high exactly while both the interrupt enable (bit 2) and the end flag are 1.
- R9: With source code 00 (pin) and edge select 0, the channel starts a unit only while the synchronized `ext_req_n` is low. Before each cycle-steal unit the pin is sampled again.
- R10: With source 00 and edge select 1, each falling edge of `ext_req_n` starts exactly one cycle-steal unit. Holding the pin low starts no more units.
- R11: With source code 01 (peripheral), `periph_req_n` is always edge-sensed, whatever the edge select bit holds.
- R12: On a channel whose index is not below `NUM_EDGE_CHANS`, the edge select bit ignores writes and reads back 0, and the pin is level-sensed.
- R13: If the count reaches zero in the same cycle as a software write that clears the end flag, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 9 | Control word write data |
| ctl_rdata | output | 9 | Control word readback, including the end flag |
| cnt_we | input | 1 | Transfer count write strobe |
| cnt_wdata | input | CNT_W | Transfer count write data |
| cnt_rdata | output | CNT_W | Remaining unit count |
| ext_req_n | input | 1 | External request pin, active low, asynchronous |
| periph_req_n | input | 1 | On-chip peripheral request line, active low |
| bus_req | output | 1 | Bus request held by the channel |
| bus_grant | input | 1 | Bus granted to the channel |
| bus_done | input | 1 | One bus cycle finished (one-cycle pulse) |
| cyc_size | output | 2 | Size of the current bus cycle (00 byte, 01 word, 10 longword) |
| irq | output | 1 | Transfer-end interrupt request |

## Verification
The end flag has two writers, and both can act in the same clock edge. One is the count reaching zero at the last unit. The other is a software control write that clears the flag. The bench watches for the final `bus_done` pulse of a one-unit transfer and places a control write with bit 1 = 0 in that same cycle. It then requires the flag and `irq` to read back as set, and a later separate clearing write to drop both.

// File: rtl/dma_chan_pkg.sv
`timescale 1ns/1ps
package dma_chan_pkg;

   localparam int CTL_W = 9;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_WORD = 2'b01,
      SZ_LONG = 2'b10,
      SZ_LINE = 2'b11
   } size_e;

   localparam logic [1:0] SRC_PIN    = 2'b00;
   localparam logic [1:0] SRC_PERIPH = 2'b01;

   typedef struct packed {
      logic [1:0] src;
      logic       edge_sel;
      logic       burst;
      logic [1:0] size;
      logic       ie;
      logic       te;
      logic       en;
   } ctl_t;

   typedef enum logic [1:0] {
      ST_IDLE = 2'b00,
      ST_REQ  = 2'b01,
      ST_XFER = 2'b10
   } seq_st_e;

endpackage

// File: rtl/dma_req_detect.sv
`timescale 1ns/1ps
module dma_req_detect
   import dma_chan_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter bit HAS_EDGE    = 1'b1
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] src,
   input  logic       edge_sel,
   input  logic       ext_req_n,
   input  logic       periph_req_n,
   input  logic       unit_start,
   output logic       pending
);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("dma_req_detect: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic                   pin_n;
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   synced_n;
   logic                   fall;
   logic                   use_edge;
   logic                   latch_q;
   logic                   is_auto;

   assign is_auto  = src[1];
   assign pin_n    = (src == SRC_PERIPH) ? periph_req_n : ext_req_n;
   assign synced_n = sync_q[SYNC_STAGES-1];
   assign fall     = prev_q & ~synced_n;

   generate
      if (HAS_EDGE) begin : g_sel
         assign use_edge = (src == SRC_PERIPH) | edge_sel;
      end else begin : g_fixed
         assign use_edge = (src == SRC_PERIPH);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '1;
         prev_q <= 1'b1;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
         prev_q <= synced_n;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 latch_q <= 1'b0;
      else if (!use_edge)         latch_q <= 1'b0;
      else if (fall)              latch_q <= 1'b1;
      else if (unit_start)        latch_q <= 1'b0;
   end

   always_comb begin
      if (is_auto)       pending = 1'b1;
      else if (use_edge) pending = latch_q;
      else               pending = ~synced_n;
   end

endmodule

// File: rtl/dma_tcount.sv
`timescale 1ns/1ps
module dma_tcount #(
   parameter int CNT_W = 16
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cnt_we,
   input  logic [CNT_W-1:0] cnt_wdata,
   input  logic             dec,
   input  logic             te_clr,
   output logic [CNT_W-1:0] cnt,
   output logic             cnt_last,
   output logic             cnt_zero,
   output logic             te
);

   generate
      if (CNT_W < 2) begin : g_bad_cnt
         $error("dma_tcount: CNT_W must be at least 2");
      end
   endgenerate

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   assign cnt_last = (cnt == ONE);
   assign cnt_zero = (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (cnt_we) cnt <= cnt_wdata;
      else if (dec)    cnt <= cnt - ONE;
   end

   // terminal set has priority over a software clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               te <= 1'b0;
      else if (dec && cnt_last) te <= 1'b1;
      else if (te_clr)          te <= 1'b0;
   end

endmodule

// File: rtl/dma_xfer_seq.sv
`timescale 1ns/1ps
module dma_xfer_seq
   import dma_chan_pkg::*;
#(
   parameter int LINE_BEATS = 4
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_ok,
   input  logic       en,
   input  logic       burst,
   input  logic [1:0] size,
   input  logic       cnt_last,
   input  logic       bus_grant,
   input  logic       bus_done,
   output logic       bus_req,
   output logic       unit_start,
   output logic       unit_end,
   output logic [1:0] cyc_size
);

   generate
      if (LINE_BEATS < 2) begin : g_bad_beats
         $error("dma_xfer_seq: LINE_BEATS must be at least 2");
      end
   endgenerate

   localparam int BW = $clog2(LINE_BEATS);
   localparam logic [BW-1:0] BEAT_MAX = BW'(LINE_BEATS - 1);

   seq_st_e        st_q;
   logic [BW-1:0]  beat_q;
   logic           is_line;
   logic           beat_last;

   assign is_line    = (size == SZ_LINE);
   assign beat_last  = !is_line || (beat_q == BEAT_MAX);
   assign unit_start = (st_q == ST_IDLE) && start_ok;
   assign unit_end   = (st_q == ST_XFER) && bus_done && beat_last;
   assign bus_req    = (st_q != ST_IDLE);
   assign cyc_size   = is_line ? SZ_LONG : size;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         beat_q <= '0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               beat_q <= '0;
               if (start_ok) st_q <= ST_REQ;
            end
            ST_REQ: begin
               if (bus_grant) st_q <= ST_XFER;
            end
            ST_XFER: begin
               if (bus_done) begin
                  if (beat_last) begin
                     beat_q <= '0;
                     if (!(burst && en && !cnt_last)) st_q <= ST_IDLE;
                  end else begin
                     beat_q <= beat_q + 1'b1;
                  end
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/dma_chan_ctl.sv
`timescale 1ns/1ps
module dma_chan_ctl
   import dma_chan_pkg::*;
#(
   parameter int CHAN_ID        = 0,
   parameter int NUM_EDGE_CHANS = 2,
   parameter int CNT_W          = 16,
   parameter int SYNC_STAGES    = 2,
   parameter int LINE_BEATS     = 4
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_we,
   input  logic [CTL_W-1:0] ctl_wdata,
   output logic [CTL_W-1:0] ctl_rdata,
   input  logic             cnt_we,
   input  logic [CNT_W-1:0] cnt_wdata,
   output logic [CNT_W-1:0] cnt_rdata,
   input  logic             ext_req_n,
   input  logic             periph_req_n,
   output logic             bus_req,
   input  logic             bus_grant,
   input  logic             bus_done,
   output logic [1:0]       cyc_size,
   output logic             irq
);

   generate
      if (CHAN_ID < 0 || NUM_EDGE_CHANS < 0) begin : g_bad_id
         $error("dma_chan_ctl: channel index parameters must be non-negative");
      end
   endgenerate

   localparam bit HAS_EDGE = (CHAN_ID < NUM_EDGE_CHANS);

   ctl_t       wr;
   ctl_t       rd;
   logic       en_q, ie_q, burst_q, edge_q;
   logic [1:0] size_q, src_q;
   logic       te, cnt_last, cnt_zero;
   logic       pending, start_ok, unit_start, unit_end;

   assign wr = ctl_t'(ctl_wdata);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         ie_q    <= 1'b0;
         burst_q <= 1'b0;
         size_q  <= SZ_BYTE;
         src_q   <= SRC_PIN;
      end else if (ctl_we) begin
         en_q    <= wr.en;
         ie_q    <= wr.ie;
         burst_q <= wr.burst;
         size_q  <= wr.size;
         src_q   <= wr.src;
      end
   end

   generate
      if (HAS_EDGE) begin : g_edge_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      edge_q <= 1'b0;
            else if (ctl_we) edge_q <= wr.edge_sel;
         end
      end else begin : g_no_edge_bit
         assign edge_q = 1'b0;
      end
   endgenerate

   dma_req_detect #(
      .SYNC_STAGES (SYNC_STAGES),
      .HAS_EDGE    (HAS_EDGE)
   ) u_detect (
      .clk          (clk),
      .rst_n        (rst_n),
      .src          (src_q),
      .edge_sel     (edge_q),
      .ext_req_n    (ext_req_n),
      .periph_req_n (periph_req_n),
      .unit_start   (unit_start),
      .pending      (pending)
   );

   dma_tcount #(
      .CNT_W (CNT_W)
   ) u_count (
      .clk       (clk),
      .rst_n     (rst_n),
      .cnt_we    (cnt_we),
      .cnt_wdata (cnt_wdata),
      .dec       (unit_end),
      .te_clr    (ctl_we && !wr.te),
      .cnt       (cnt_rdata),
      .cnt_last  (cnt_last),
      .cnt_zero  (cnt_zero),
      .te        (te)
   );

   assign start_ok = en_q && !te && !cnt_zero && pending;

   dma_xfer_seq #(
      .LINE_BEATS (LINE_BEATS)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_ok   (start_ok),
      .en         (en_q),
      .burst      (burst_q),
      .size       (size_q),
      .cnt_last   (cnt_last),
      .bus_grant  (bus_grant),
      .bus_done   (bus_done),
      .bus_req    (bus_req),
      .unit_start (unit_start),
      .unit_end   (unit_end),
      .cyc_size   (cyc_size)
   );

   always_comb begin
      rd          = '0;
      rd.en       = en_q;
      rd.te       = te;
      rd.ie       = ie_q;
      rd.size     = size_q;
      rd.burst    = burst_q;
      rd.edge_sel = edge_q;
      rd.src      = src_q;
   end

   assign ctl_rdata = rd;
   assign irq       = ie_q && te;

endmodule

// File: rtl/dma_chan_ctl_chk.sv
`timescale 1ns/1ps
module dma_chan_ctl_chk
   import dma_chan_pkg::*;
#(
   parameter int CNT_W = 16
)(
   input logic             clk,
   input logic             rst_n,
   input logic             cnt_we,
   input logic             bus_req,
   input logic [CTL_W-1:0] ctl_rdata,
   input logic [CNT_W-1:0] cnt_rdata,
   input logic             irq
);

   assert_zero_count_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_rdata == '0 && !bus_req) |=> !bus_req);

   assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(cnt_we) && cnt_rdata != $past(cnt_rdata))
         |-> (cnt_rdata == $past(cnt_rdata) - CNT_W'(1)));

   assert_flag_at_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ctl_rdata[1]) && !$past(cnt_we)) |-> (cnt_rdata == '0));

   assert_flag_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_rdata[1] && !bus_req) |=> !bus_req);

   assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (ctl_rdata[1] && ctl_rdata[2]));

endmodule

bind dma_chan_ctl dma_chan_ctl_chk #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cnt_we    (cnt_we),
   .bus_req   (bus_req),
   .ctl_rdata (ctl_rdata),
   .cnt_rdata (cnt_rdata),
   .irq       (irq)
);

// File: tb/test_dma_chan_ctl.sv
`timescale 1ns/1ps
module test_dma_chan_ctl;

   localparam int CW = 16;
   localparam logic [1:0] S_PIN = 2'b00, S_PER = 2'b01, S_AUTO = 2'b10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic          ctl_we = 0, cnt_we = 0;
   logic [8:0]    ctl_wdata = '0, ctl_rdata;
   logic [CW-1:0] cnt_wdata = '0, cnt_rdata;
   logic          ext_n = 1, per_n = 1;
   logic          breq, bgnt = 0, bdone = 0, irq;
   logic [1:0]    csz;

   logic          ctl2_we = 0, cnt2_we = 0;
   logic [8:0]    ctl2_wdata = '0, ctl2_rdata;
   logic [CW-1:0] cnt2_wdata = '0, cnt2_rdata;
   logic          ext2_n = 1;
   logic          breq2, bgnt2 = 0, bdone2 = 0, irq2;
   logic [1:0]    csz2;

   dma_chan_ctl #(.CHAN_ID(0), .CNT_W(CW)) i_dma_chan_ctl (
      .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
      .ctl_rdata(ctl_rdata), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
      .cnt_rdata(cnt_rdata), .ext_req_n(ext_n), .periph_req_n(per_n),
      .bus_req(breq), .bus_grant(bgnt), .bus_done(bdone), .cyc_size(csz), .irq(irq));

   dma_chan_ctl #(.CHAN_ID(2), .CNT_W(CW)) i_dma_chan_ctl_c2 (
      .clk(clk), .rst_n(rst_n), .ctl_we(ctl2_we), .ctl_wdata(ctl2_wdata),
      .ctl_rdata(ctl2_rdata), .cnt_we(cnt2_we), .cnt_wdata(cnt2_wdata),
      .cnt_rdata(cnt2_rdata), .ext_req_n(ext2_n), .periph_req_n(1'b1),
      .bus_req(breq2), .bus_grant(bgnt2), .bus_done(bdone2), .cyc_size(csz2), .irq(irq2));

   int n_cmp = 0, n_bad = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // bus responders: grant follows request, done pulses every other cycle
   always @(negedge clk) begin
      bgnt   <= breq;
      bdone  <= breq && bgnt && !bdone;
      bgnt2  <= breq2;
      bdone2 <= breq2 && bgnt2 && !bdone2;
   end

   typedef struct packed { logic [1:0] sz; logic hold; } exp_t;
   exp_t q[$];
   logic hold_pend = 0, hold_exp = 0;

   // monitor: pops one expected item per bus cycle, then checks the request after it
   always @(negedge clk) begin
      #1;
      if (rst_n) begin
         if (hold_pend) begin
            chk("R5 R6 request after cycle", breq, hold_exp);
            hold_pend = 0;
         end
         if (bdone) begin
            if (q.size() == 0) begin
               n_cmp++; n_bad++;
               $display("FAIL R2 unexpected bus cycle: actual 1 expected 0");
            end else begin
               exp_t e;
               e = q.pop_front();
               chk("R3 cycle size", csz, e.sz);
               hold_pend = 1;
               hold_exp  = e.hold;
            end
         end
      end
   end

   // driver: pushes the expected cycles of a programmed transfer
   task automatic expect_units(input logic [1:0] sz, input logic burst, input int units);
      int beats = (sz == 2'b11) ? 4 : 1;
      for (int u = 0; u < units; u++)
         for (int b = 0; b < beats; b++) begin
            exp_t e;
            e.sz   = (sz == 2'b11) ? 2'b10 : sz;
            e.hold = (b < beats - 1) || (burst && u < units - 1);
            q.push_back(e);
         end
   endtask

   function automatic logic [8:0] mk(input logic [1:0] src, input logic esel,
      input logic burst, input logic [1:0] sz, input logic ie, input logic te, input logic en);
      return {src, esel, burst, sz, ie, te, en};
   endfunction

   task automatic wr_ctl(input logic [8:0] d);
      @(negedge clk); #2; ctl_we = 1; ctl_wdata = d;
      @(negedge clk); #2; ctl_we = 0;
   endtask

   task automatic wr_cnt(input logic [CW-1:0] d);
      @(negedge clk); #2; cnt_we = 1; cnt_wdata = d;
      @(negedge clk); #2; cnt_we = 0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
      #3;
   endtask

   task automatic drain(input string tag);
      int k = 0;
      while ((q.size() != 0 || breq || hold_pend) && k < 3000) begin
         @(negedge clk); k++;
      end
      #3;
      chk(tag, k < 3000, 1);
   endtask

   initial begin
      #1_000_000;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      #3;
      // R1 reset state
      chk("R1 control", ctl_rdata, 0);
      chk("R1 count", cnt_rdata, 0);
      chk("R1 bus_req", breq, 0);
      chk("R1 irq", irq, 0);
      rst_n = 1;
      idle(2);

      // R2 R3 R4 R5: auto, byte, cycle-steal, three units
      wr_cnt(3);
      expect_units(2'b00, 0, 3);
      wr_ctl(mk(S_AUTO, 0, 0, 2'b00, 0, 0, 1));
      drain("R2 auto transfer");
      chk("R4 count at end", cnt_rdata, 0);
      chk("R4 end flag", ctl_rdata[1], 1);
      chk("R8 irq disabled", irq, 0);

      // R3 word size
      wr_cnt(1);
      expect_units(2'b01, 0, 1);
      wr_ctl(mk(S_AUTO, 0, 0, 2'b01, 0, 0, 1));
      drain("R3 word transfer");

      // R6 R8: burst longword with interrupt
      wr_cnt(2);
      expect_units(2'b10, 1, 2);
      wr_ctl(mk(S_AUTO, 0, 1, 2'b10, 1, 0, 1));
      drain("R6 burst transfer");
      chk("R8 irq raised", irq, 1);
      wr_ctl(mk(S_AUTO, 0, 1, 2'b10, 0, 1, 1));
      chk("R8 irq after ie cleared", irq, 0);
      chk("R7 write of 1 keeps flag", ctl_rdata[1], 1);

      // R7: flag blocks requests until cleared
      wr_cnt(2);
      idle(20);
      chk("R7 no request while flag set", breq, 0);
      chk("R7 count untouched", cnt_rdata, 2);
      expect_units(2'b00, 0, 2);
      wr_ctl(mk(S_AUTO, 0, 0, 2'b00, 0, 0, 1));
      drain("R7 resumes after clear");
      chk("R7 count after resume", cnt_rdata, 0);

      // R3 R6: 16-byte units in burst
      wr_cnt(2);
      expect_units(2'b11, 1, 2);
      wr_ctl(mk(S_AUTO, 0, 1, 2'b11, 0, 0, 1));
      drain("R3 line burst");
      chk("R4 line units counted", cnt_rdata, 0);

      // R3 R5: 16-byte unit in cycle-steal
      wr_cnt(1);
      expect_units(2'b11, 0, 1);
      wr_ctl(mk(S_AUTO, 0, 0, 2'b11, 0, 0, 1));
      drain("R3 line cycle-steal");

      // R2 zero count: no request
      wr_cnt(0);
      wr_ctl(mk(S_AUTO, 0, 0, 2'b00, 0, 0, 1));
      idle(20);
      chk("R2 zero count idle", breq, 0);
      chk("R2 zero count flag", ctl_rdata[1], 0);

      // R9 level sensing
      wr_ctl(mk(S_PIN, 0, 0, 2'b00, 0, 0, 0));
      wr_cnt(2);
      wr_ctl(mk(S_PIN, 0, 0, 2'b00, 0, 0, 1));
      idle(20);
      chk("R9 pin high no request", cnt_rdata, 2);
      expect_units(2'b00, 0, 2);
      ext_n = 0;
      drain("R9 level transfers");
      chk("R9 count after level", cnt_rdata, 0);
      ext_n = 1;
      idle(5);

      // R10 edge sensing
      wr_cnt(3);
      wr_ctl(mk(S_PIN, 1, 0, 2'b00, 0, 0, 1));
      chk("R10 edge bit stored on low channel", ctl_rdata[6], 1);
      idle(10);
      chk("R10 no edge no transfer", cnt_rdata, 3);
      expect_units(2'b00, 0, 1);
      ext_n = 0; idle(5); ext_n = 1;
      drain("R10 first edge");
      idle(10);
      chk("R10 one unit per edge", cnt_rdata, 2);
      expect_units(2'b00, 0, 1);
      ext_n = 0;
      drain("R10 second edge");
      idle(20);
      chk("R10 held low adds nothing", cnt_rdata, 1);
      ext_n = 1;
      idle(5);

      // R11 peripheral source is edge-sensed even with edge select 0
      wr_cnt(3);
      wr_ctl(mk(S_PER, 0, 0, 2'b00, 0, 0, 1));
      expect_units(2'b00, 0, 1);
      per_n = 0;
      drain("R11 peripheral edge");
      idle(20);
      chk("R11 held low gives one unit", cnt_rdata, 2);
      per_n = 1;
      wr_ctl(mk(S_PER, 0, 0, 2'b00, 0, 0, 0));

      // R13: end flag set and software clear in the same cycle
      wr_cnt(1);
      expect_units(2'b00, 0, 1);
      wr_ctl(mk(S_AUTO, 0, 0, 2'b00, 1, 0, 1));
      do begin @(negedge clk); #2; end while (!bdone);
      ctl_we = 1; ctl_wdata = mk(S_AUTO, 0, 0, 2'b00, 1, 0, 0);
      @(negedge clk); #2; ctl_we = 0;
      #1;
      chk("R13 set wins over clear", ctl_rdata[1], 1);
      chk("R13 irq held", irq, 1);
      chk("R13 count zero", cnt_rdata, 0);
      wr_ctl(mk(S_AUTO, 0, 0, 2'b00, 1, 0, 0));
      chk("R8 irq drops with flag", irq, 0);
      drain("R13 drain");

      // R12 high channel: edge bit not writable, level sensing
      @(negedge clk); #2; cnt2_we = 1; cnt2_wdata = 3;
      @(negedge clk); #2; cnt2_we = 0;
      ctl2_we = 1; ctl2_wdata = mk(S_PIN, 1, 0, 2'b00, 0, 0, 1);
      @(negedge clk); #2; ctl2_we = 0;
      #1;
      chk("R12 edge bit reads 0", ctl2_rdata[6], 0);
      ext2_n = 0;
      idle(100);
      chk("R12 level run to completion", cnt2_rdata, 0);
      chk("R12 flag set", ctl2_rdata[1], 1);
      ext2_n = 1;

      idle(5);
      chk("R2 scoreboard empty", q.size(), 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule